// File: doc/BRIEF.md
# Strided Vector Memory Address Generator

This block turns one vector load or store command into a stream of per-element requests to a memory split across word-interleaved banks. A command gives a base word address, a stride and an element count. The block then walks the element addresses in order and sends at most one request per cycle. Each request goes to the bank picked by the low bits of its word address. Every bank is single-ported and stays occupied for a fixed number of cycles after it takes a request. The block keeps one busy down-counter per bank, and the element stream waits whenever the next element's bank is still occupied.

Load data comes back from the memory tagged with its element index and lands in an internal vector register. Store data for each element is read from that same register. Host-side ports fill the register before a store and read it back after a load. The stride and the bank count together set the rate: a stride with no common factor with the bank count streams one element per cycle, while a stride of zero or a multiple of the bank count spaces elements by the full bank latency. NUM_BANKS must be a power of two.

Top module: `vec_agen`

## Requirements
- R1: `req_bank` of every request equals the request's word address modulo NUM_BANKS (16 by default), that is, its low four bits.
- R2: Element i of a command is requested with `req_elem` = i and `req_addr` = (base + i*stride) mod 2^ADDR_W. Elements are issued in increasing index order.
- R3: A command issues exactly min(vlen, MAX_VLEN) requests, with MAX_VLEN = 64. A length of zero issues none, and any length above 64 is treated as 64.
- R4: Two requests to the same bank are at least BANK_LAT (11) cycles apart. A pending element is issued in the first cycle its bank has been free for that long.
- R5: With an odd stride (coprime with 16 banks), a command of n elements issues one element per cycle, so the last issue comes n-1 cycles after the first.
- R6: With stride 0, every element targets one bank, and issues are spaced exactly BANK_LAT cycles apart.
- R7: A load response (`rsp_valid`, `rsp_elem`, `rsp_data`) writes `rsp_data` into vector register entry `rsp_elem`, and `vr_rdata` later shows it for `vr_ridx` = `rsp_elem`.
- R8: A store command drives `req_we` = 1, and its `req_wdata` equals the vector register entry of the element being issued. A load drives `req_we` = 0.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse in the cycle after the last issue (store) or the last accepted response (load), and `busy` is low in that cycle. No request is issued while `busy` is low.
- R10: A `start` that arrives while `busy` is high is ignored: the running command's addresses and count are unchanged.
- R11: Bank busy counters carry across command boundaries, so a new command's first element waits for a bank still occupied by the previous command.
- R12: During reset, `busy`, `done` and `req_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a command when idle |
| is_store | input | 1 | Command type: 1 store, 0 load |
| base_addr | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Word distance between consecutive elements |
| vlen | input | LEN_W | Number of elements (clamped to MAX_VLEN) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Element request issued this cycle |
| req_we | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Word address of the request |
| req_bank | output | BANK_W | Target bank of the request |
| req_elem | output | IDX_W | Element index of the request |
| req_wdata | output | DATA_W | Store data for the request |
| rsp_valid | input | 1 | Load data returning |
| rsp_elem | input | IDX_W | Element index of the returning data |
| rsp_data | input | DATA_W | Returning load data |
| vr_we | input | 1 | Host write to the vector register |
| vr_widx | input | IDX_W | Host write index |
| vr_wdata | input | DATA_W | Host write data |
| vr_ridx | input | IDX_W | Host read index |
| vr_rdata | output | DATA_W | Host read data (combinational) |

## Verification
The hardest case to reach is a bank that is still occupied when a command starts, because the previous command left it busy. Loads finish too late for this to show: the bank latency has already run out by the time the last response comes back. The bench therefore runs two short stores back to back, each with a stride equal to the bank count, and checks that the second command's first issue lands exactly one bank latency after the first command's last issue. Stall patterns within a single command come from strides of 0, 2 and 16, and from an ignored start pulsed into the middle of a slow stride-0 load.

// File: rtl/vag_pkg.sv
package vag_pkg;
  // Transfer direction held for the duration of a command.
  typedef enum logic {
    XFER_LOAD  = 1'b0,
    XFER_STORE = 1'b1
  } xfer_e;
endpackage

// File: rtl/vag_bank_timers.sv
// One occupancy down-counter per bank; a bank is free when its counter is zero.
module vag_bank_timers #(
  parameter  int NUM_BANKS = 16,
  parameter  int LAT       = 11,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int CNT_W     = $clog2(LAT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  logic [BANK_W-1:0]    issue_bank,
  output logic [NUM_BANKS-1:0] bank_free
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit, cnt_en;

    assign hit    = issue && (issue_bank == BANK_W'(b));
    assign cnt_en = hit || (cnt_q != '0);

    always_comb begin
      cnt_d = cnt_q;
      if (hit)                 cnt_d = CNT_W'(LAT - 1);
      else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign bank_free[b] = (cnt_q == '0);
  end

endmodule

// File: rtl/vag_addr_seq.sv
// Element address and index walker.
module vag_addr_seq #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_elem
);

  logic [ADDR_W-1:0] addr_d;
  logic [LEN_W-1:0]  elem_d;
  logic              seq_en;

  assign seq_en = load || advance;

  always_comb begin
    if (load) begin
      addr_d = base;
      elem_d = '0;
    end else begin
      addr_d = cur_addr + step;
      elem_d = cur_elem + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_elem <= '0;
    end else if (seq_en) begin
      cur_addr <= addr_d;
      cur_elem <= elem_d;
    end
  end

endmodule

// File: rtl/vag_vreg.sv
// Vector register: two write ports (port a wins on a clash), two read ports.
module vag_vreg #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 64,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_data,
  input  logic [IDX_W-1:0]  r0_idx,
  output logic [DATA_W-1:0] r0_data,
  input  logic [IDX_W-1:0]  r1_idx,
  output logic [DATA_W-1:0] r1_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_idx] <= b_data;
    if (a_we) mem[a_idx] <= a_data;
  end

  assign r0_data = mem[r0_idx];
  assign r1_data = mem[r1_idx];

endmodule

// File: rtl/vec_agen.sv
module vec_agen #(
  parameter  int NUM_BANKS = 16,
  parameter  int BANK_LAT  = 11,
  parameter  int ADDR_W    = 16,
  parameter  int DATA_W    = 32,
  parameter  int MAX_VLEN  = 64,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int IDX_W     = $clog2(MAX_VLEN),
  localparam int LEN_W     = $clog2(MAX_VLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vlen,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BANK_W-1:0] req_bank,
  output logic [IDX_W-1:0]  req_elem,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_elem,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              vr_we,
  input  logic [IDX_W-1:0]  vr_widx,
  input  logic [DATA_W-1:0] vr_wdata,
  input  logic [IDX_W-1:0]  vr_ridx,
  output logic [DATA_W-1:0] vr_rdata
);
  import vag_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic                 run_q, run_d, done_q;
  xfer_e                kind_q, kind_d;
  logic [ADDR_W-1:0]    stride_q;
  logic [LEN_W-1:0]     vlen_q, vlen_lim;
  logic [LEN_W-1:0]     rsp_cnt_q, rsp_cnt_d, rsp_next, iss_next;
  logic [ADDR_W-1:0]    cur_addr;
  logic [LEN_W-1:0]     cur_elem;
  logic [NUM_BANKS-1:0] bank_free;
  logic [BANK_W-1:0]    bank_sel;
  logic                 accept, more, issue, rsp_hit, finish, ctl_en;
  logic [DATA_W-1:0]    store_data;

  assign vlen_lim = (vlen > LEN_W'(MAX_VLEN)) ? LEN_W'(MAX_VLEN) : vlen;
  assign accept   = start && !run_q;
  assign bank_sel = cur_addr[BANK_W-1:0];
  assign more     = cur_elem < vlen_q;
  assign issue    = run_q && more && bank_free[bank_sel];
  assign rsp_hit  = run_q && (kind_q == XFER_LOAD) && rsp_valid;
  assign iss_next = cur_elem + LEN_W'(issue);
  assign rsp_next = rsp_cnt_q + LEN_W'(rsp_hit);
  assign finish   = run_q && (iss_next == vlen_q) &&
                    ((kind_q == XFER_STORE) || (rsp_next == vlen_q));
  assign ctl_en   = accept || run_q;

  always_comb begin
    kind_d    = is_store ? XFER_STORE : XFER_LOAD;
    run_d     = run_q;
    rsp_cnt_d = rsp_next;
    if (accept) begin
      run_d     = 1'b1;
      rsp_cnt_d = '0;
    end else if (finish) begin
      run_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      run_q     <= 1'b0;
      rsp_cnt_q <= '0;
      kind_q    <= XFER_LOAD;
      stride_q  <= '0;
      vlen_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      if (ctl_en) begin
        run_q     <= run_d;
        rsp_cnt_q <= rsp_cnt_d;
      end
      if (accept) begin
        kind_q   <= kind_d;
        stride_q <= stride;
        vlen_q   <= vlen_lim;
      end
      done_q <= finish;
    end
  end

  vag_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (accept),
    .advance  (issue),
    .base     (base_addr),
    .step     (stride_q),
    .cur_addr (cur_addr),
    .cur_elem (cur_elem)
  );

  vag_bank_timers #(.NUM_BANKS(NUM_BANKS), .LAT(BANK_LAT)) u_timers (
    .clk        (clk),
    .rst_n      (rst_q),
    .issue      (issue),
    .issue_bank (bank_sel),
    .bank_free  (bank_free)
  );

  vag_vreg #(.DATA_W(DATA_W), .DEPTH(MAX_VLEN)) u_vreg (
    .clk     (clk),
    .a_we    (rsp_hit),
    .a_idx   (rsp_elem),
    .a_data  (rsp_data),
    .b_we    (vr_we),
    .b_idx   (vr_widx),
    .b_data  (vr_wdata),
    .r0_idx  (cur_elem[IDX_W-1:0]),
    .r0_data (store_data),
    .r1_idx  (vr_ridx),
    .r1_data (vr_rdata)
  );

  assign busy      = run_q;
  assign done      = done_q;
  assign req_valid = issue;
  assign req_we    = (kind_q == XFER_STORE);
  assign req_addr  = cur_addr;
  assign req_bank  = bank_sel;
  assign req_elem  = cur_elem[IDX_W-1:0];
  assign req_wdata = store_data;

endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
  parameter  int NUM_BANKS = 16,
  parameter  int BANK_LAT  = 11,
  parameter  int ADDR_W    = 16,
  parameter  int MAX_VLEN  = 64,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int IDX_W     = $clog2(MAX_VLEN),
  localparam int LEN_W     = $clog2(MAX_VLEN + 1),
  localparam int CNT_W     = $clog2(BANK_LAT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BANK_W-1:0] req_bank,
  input logic [IDX_W-1:0]  req_elem,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] stride_q,
  input logic [LEN_W-1:0]  vlen_q
);

  logic [ADDR_W-1:0] last_addr;
  logic [IDX_W-1:0]  last_elem;
  logic [BANK_W-1:0] last_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_elem <= '0;
      last_bank <= '0;
    end else if (req_valid) begin
      last_addr <= req_addr;
      last_elem <= req_elem;
      last_bank <= req_bank;
    end
  end

  // R2: consecutive elements step by the stride and by one index
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_elem != '0) |->
      (req_addr == last_addr + stride_q && req_elem == last_elem + 1'b1));

  // R3: no element index at or past the command length
  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (LEN_W'(req_elem) < vlen_q));

  // R6: with stride 0 every element stays on the same bank
  p_stride0_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_elem != '0 && stride_q == '0) |-> (req_bank == last_bank));

  // R9: requests only while busy; done is a single pulse that ends busy
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: per-bank spacing measured independently of the design's timers
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
    logic [CNT_W-1:0] gap;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      gap <= CNT_W'(BANK_LAT);
      else if (req_valid && req_bank == BANK_W'(b))    gap <= CNT_W'(1);
      else if (gap < CNT_W'(BANK_LAT))                 gap <= gap + 1'b1;
    end
    p_bank_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bank == BANK_W'(b)) |-> (gap >= CNT_W'(BANK_LAT)));
  end

endmodule

bind vec_agen vag_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_LAT  (BANK_LAT),
  .ADDR_W    (ADDR_W),
  .MAX_VLEN  (MAX_VLEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_bank  (req_bank),
  .req_elem  (req_elem),
  .busy      (busy),
  .done      (done),
  .stride_q  (stride_q),
  .vlen_q    (vlen_q)
);

// File: tb/vec_agen_tb.sv
`timescale 1ns/1ps
module vec_agen_tb;
  localparam int NB  = 16;
  localparam int LAT = 11;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int MV  = 64;
  localparam int IW  = 6;
  localparam int LW  = 7;
  localparam int D   = LAT - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic start, is_store, vr_we;
  logic [AW-1:0] base_addr, stride;
  logic [LW-1:0] vlen;
  logic busy, done, req_valid, req_we;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_bank;
  logic [IW-1:0] req_elem, rsp_elem, vr_widx, vr_ridx;
  logic [DW-1:0] req_wdata, rsp_data, vr_wdata, vr_rdata;
  logic          rsp_valid;

  always #2 clk = ~clk;

  vec_agen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .base_addr(base_addr), .stride(stride), .vlen(vlen),
    .busy(busy), .done(done), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_bank(req_bank), .req_elem(req_elem),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_elem(rsp_elem),
    .rsp_data(rsp_data), .vr_we(vr_we), .vr_widx(vr_widx),
    .vr_wdata(vr_wdata), .vr_ridx(vr_ridx), .vr_rdata(vr_rdata)
  );

  int checks = 0, errors = 0;

  function automatic logic [DW-1:0] mem_word(int a);
    logic [15:0] w = a[15:0];
    return {w ^ 16'hA5C3, w};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model: load data returns D cycles after issue.
  logic          pv [D];
  logic [IW-1:0] pe [D];
  logic [DW-1:0] pd [D];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < D; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= req_valid && !req_we;
      pe[0] <= req_elem;
      pd[0] <= mem_word(int'(req_addr));
      for (int k = 1; k < D; k++) begin
        pv[k] <= pv[k-1]; pe[k] <= pe[k-1]; pd[k] <= pd[k-1];
      end
    end
  end
  assign rsp_valid = pv[D-1];
  assign rsp_elem  = pe[D-1];
  assign rsp_data  = pd[D-1];

  // Behavioural reference model, one step per cycle.
  int cyc = 0;
  int free_at [NB];
  logic [DW-1:0] shadow [MV];
  bit m_run = 0, m_store = 0, m_done = 0;
  int m_addr, m_stride, m_vlen, m_elem, m_rsp;
  int m_iss, first_iss, last_iss, obs_iss;

  initial for (int b = 0; b < NB; b++) free_at[b] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_valid;
      int bk;
      bk = m_addr % NB;
      e_valid = m_run && (m_elem < m_vlen) && (cyc >= free_at[bk]);
      chk(req_valid === e_valid, "R4", "req_valid", req_valid, e_valid);
      if (req_valid && e_valid) begin
        chk(req_addr == m_addr[AW-1:0], "R2", "req_addr", req_addr, m_addr);
        chk(req_elem == m_elem[IW-1:0], "R2", "req_elem", req_elem, m_elem);
        chk(req_bank == bk[3:0], "R1", "req_bank", req_bank, bk);
        chk(req_we == m_store, "R8", "req_we", req_we, m_store);
        if (m_store)
          chk(req_wdata == shadow[m_elem], "R8", "req_wdata", req_wdata, shadow[m_elem]);
      end
      if (req_valid) obs_iss++;
      chk(done === m_done, "R9", "done", done, m_done);
      chk(busy === m_run, "R9", "busy", busy, m_run);
      // advance
      m_done = 0;
      if (m_run) begin
        if (e_valid) begin
          free_at[bk] = cyc + LAT;
          if (m_iss == 0) first_iss = cyc;
          last_iss = cyc;
          m_iss++;
          m_addr = (m_addr + m_stride) & 32'hFFFF;
          m_elem++;
        end
        if (!m_store && rsp_valid) begin
          shadow[rsp_elem] = rsp_data;
          m_rsp++;
        end
        if (m_elem == m_vlen && (m_store || m_rsp == m_vlen)) begin
          m_done = 1; m_run = 0;
        end
      end else if (start) begin
        m_run = 1; m_store = is_store; m_addr = int'(base_addr);
        m_stride = int'(stride); m_vlen = (int'(vlen) > MV) ? MV : int'(vlen);
        m_elem = 0; m_rsp = 0; m_iss = 0; obs_iss = 0;
      end
      if (vr_we) shadow[vr_widx] = vr_wdata;
      cyc++;
    end
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL R9 watchdog: actual no completion, expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic launch(int b, int s, int n, bit st);
    @(posedge clk); #1;
    base_addr = b[AW-1:0]; stride = s[AW-1:0]; vlen = n[LW-1:0];
    is_store = st; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
  endtask

  task automatic run_vec(int b, int s, int n, bit st);
    launch(b, s, n, st);
    wait_done();
  endtask

  task automatic readback(int b, int s, int n);
    for (int i = 0; i < n; i++) begin
      int a;
      a = (b + i * s) & 32'hFFFF;
      @(posedge clk); #1 vr_ridx = i[IW-1:0];
      @(negedge clk);
      chk(vr_rdata == mem_word(a), "R7", "vr_rdata", vr_rdata, mem_word(a));
    end
  endtask

  initial begin
    int prev_last;
    rst_n = 1'b0; start = 1'b0; is_store = 1'b0; vr_we = 1'b0;
    base_addr = '0; stride = '0; vlen = '0;
    vr_widx = '0; vr_wdata = '0; vr_ridx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R12", "busy in reset", busy, 0);
    chk(done === 1'b0, "R12", "done in reset", done, 0);
    chk(req_valid === 1'b0, "R12", "req_valid in reset", req_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R5, R7: unit stride, full length load
    run_vec(16'h0010, 1, 64, 0);
    chk(last_iss - first_iss == 63, "R5", "stride-1 issue span", last_iss - first_iss, 63);
    readback(16'h0010, 1, 64);

    // R4: stride 2 uses half the banks and stalls
    run_vec(3, 2, 20, 0);
    readback(3, 2, 20);

    // R6, R10: stride 0 with a start pulsed mid-command
    launch(5, 0, 4, 0);
    repeat (3) @(posedge clk);
    #1 base_addr = 16'h0200; stride = 1; vlen = 9; is_store = 1'b1; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done();
    chk(last_iss - first_iss == 3 * LAT, "R6", "stride-0 issue span", last_iss - first_iss, 3 * LAT);
    chk(obs_iss == 4, "R10", "issues after ignored start", obs_iss, 4);
    readback(5, 0, 4);

    // R8: store from preloaded register, stride 3
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1 vr_we = 1'b1; vr_widx = i[IW-1:0]; vr_wdata = 32'hC0DE_0000 + i * 7;
    end
    @(posedge clk); #1 vr_we = 1'b0;
    run_vec(16'h0100, 3, 16, 1);
    chk(last_iss - first_iss == 15, "R5", "stride-3 issue span", last_iss - first_iss, 15);

    // R3: zero length, then over-long length clamped
    run_vec(0, 1, 0, 0);
    chk(obs_iss == 0, "R3", "issues for vlen 0", obs_iss, 0);
    run_vec(16'h0400, 1, 127, 1);
    chk(obs_iss == 64, "R3", "issues for vlen 127", obs_iss, 64);

    // R11: back-to-back stores on bank 0
    repeat (LAT + 2) @(posedge clk);
    run_vec(16'h0020, 16, 2, 1);
    prev_last = last_iss;
    run_vec(16'h0030, 16, 2, 1);
    chk(first_iss - prev_last == LAT, "R11", "cross-command bank wait", first_iss - prev_last, LAT);

    // R2: address wraps modulo 2^16
    run_vec(16'hFFFC, 5, 8, 0);
    readback(16'hFFFC, 5, 8);

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule